// File: doc/BRIEF.md
# DMA Command Token Decoder

This block sits between a processor's command stream and a multi-channel 2D DMA engine. Commands arrive as 32-bit tokens on a valid/ready input. Each command starts with a header token that holds a command code, a channel number and, for single-parameter writes, a parameter index. The decoder then takes as many operand tokens as that code calls for. Channel configuration is either loaded by a fixed eight-operand sequence or changed one parameter at a time. It is kept in a per-channel parameter memory that the engine reads through a lookup port.

Transfer commands become one request each on a valid/ready output. The request carries the channel, the two addresses (or the fill value), and the direction, clear, fast-path and needs-acknowledge flags. The engine reports each finished transfer with a single-cycle done pulse, in the order the requests were issued. When the finished transfer needs an acknowledge, the decoder sends back an acknowledge token that holds the channel number. A small in-order queue bounds how many transfers may be in flight.

Top module: `xfer_token_decoder`

## Requirements
- R1: A header token holds the command code in bits [5:0], the channel in bits [10:6] and the parameter index in bits [13:11]. Channel and index select the parameter memory entry that a configuration write touches.
- R2: Command code 0x20 takes eight operand tokens. They are stored at parameter indices 0, 2, 3, 4, 5, 6, 7, 1 in that order: setup, stride A, crop/elements A, width A, stride B, crop/elements B, width B, height. A stored value can be read through the lookup port, with the read data valid one cycle after the address is applied.
- R3: Stored values are masked per index. Index 0 (setup) keeps bits [2:0]: connection in [1:0], and extension in bit 2 (0 zero-extend, 1 sign-extend). Index 1 (height) keeps [7:0]. Indices 2 and 5 (strides) keep all 32 bits. Indices 3 and 6 keep [15:0], with elements in [7:0] and left crop in [15:8]. Indices 4 and 7 (widths) keep [15:0].
- R4: A code with bits 0x20 and 0x01 both set, other than 0x3F, is a single-parameter write. The one token that follows is written, masked as in R3, to the header's channel and index. No other entry changes.
- R5: A code with bit 0x20 clear is a transfer. Its operands are the destination, then the source or fill value, then the to-is-var token, then a from-is-var token only when bit 0x08 is zero. The request output goes valid in the cycle after the last operand is accepted.
- R6: The request carries a2b = bit 0x04, clear = bit 0x08 and fast = bit 0x01. need_ack is 1 only when bits 0x10 and 0x02 are both zero. to_var and from_var are bit 0 of their tokens, and from_var is 0 for clear commands.
- R7: A request stays valid, with stable fields, until req_ready is high. There is exactly one handshake per transfer command. tok_ready is low while a request is valid.
- R8: Done pulses are matched to transfers in issue order. For a transfer that needs an acknowledge, ack_valid is high for one cycle, in the cycle after the done pulse is sampled, and ack_token holds the channel in bits [4:0] and zeros above. For a no-ack transfer the done pulse is consumed and no acknowledge appears.
- R9: Code 0x3F is accepted as a header and has no effect. Any other code with bit 0x20 set and bit 0x01 clear, apart from 0x20, is dropped. It writes nothing, issues nothing, and the next token is taken as a header.
- R10: At most ACK_DEPTH transfers may be awaiting done. While that many are outstanding, tok_ready is low. A done pulse with no transfer outstanding is ignored.
- R11: After reset, tok_ready is 1, req_valid is 0, ack_valid is 0 and the decoder waits for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Command token valid |
| tok_ready | output | 1 | Decoder can accept a token |
| tok_data | input | 32 | Command token |
| req_valid | output | 1 | Transfer request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_ch | output | 5 | Request channel |
| req_dst | output | 32 | Destination address |
| req_src | output | 32 | Source address or fill value |
| req_a2b | output | 1 | Direction A to B |
| req_clear | output | 1 | Fill with the value instead of copying |
| req_fast | output | 1 | Fast-path transfer |
| req_need_ack | output | 1 | Transfer needs an acknowledge token |
| req_to_var | output | 1 | Destination-is-variable flag |
| req_from_var | output | 1 | Source-is-variable flag |
| done | input | 1 | Oldest outstanding transfer finished |
| ack_valid | output | 1 | Acknowledge token valid |
| ack_token | output | 32 | Acknowledge token (channel number) |
| cfg_rd_ch | input | 5 | Lookup port channel |
| cfg_rd_idx | input | 3 | Lookup port parameter index |
| cfg_rd_data | output | 32 | Lookup port data, one cycle latency |

## Verification
A parser that loses its place in the operand count shows up on the next command. It either writes a value at the wrong parameter index, which the lookup reads expose one cycle later, or it takes an address token as a header, so the expected request never appears or comes with shifted fields. A wrong entry in the in-order done queue gives an acknowledge with the wrong channel, or one that is missing or extra, in the cycle after the matching done pulse. A miscounted occupancy shows up as tok_ready staying high with four transfers outstanding.

// File: rtl/tokdec_pkg.sv
package tokdec_pkg;
  localparam int TOK_W = 32;
  localparam int IDX_W = 3;

  localparam logic [5:0] CB_FAST  = 6'h01;
  localparam logic [5:0] CB_CHECK = 6'h02;
  localparam logic [5:0] CB_DIR   = 6'h04;
  localparam logic [5:0] CB_CLEAR = 6'h08;
  localparam logic [5:0] CB_ACK   = 6'h10;
  localparam logic [5:0] CB_CFG   = 6'h20;
  localparam logic [5:0] CMD_LOAD = 6'h20;
  localparam logic [5:0] CMD_CRUN = 6'h3F;

  typedef enum logic [1:0] {ST_HDR, ST_CFG, ST_PARAM, ST_XFER} tok_state_e;

  // position in the load sequence -> parameter index
  function automatic logic [IDX_W-1:0] seq_to_idx(input logic [IDX_W-1:0] k);
    if (k == 3'd0) return 3'd0;
    else if (k == 3'd7) return 3'd1;
    else return k + 3'd1;
  endfunction

  function automatic logic [TOK_W-1:0] field_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:       return 32'h0000_0007;
      3'd1:       return 32'h0000_00FF;
      3'd2, 3'd5: return 32'hFFFF_FFFF;
      default:    return 32'h0000_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tokdec_cfg_mem.sv
module tokdec_cfg_mem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 2 ** AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tokdec_ack_fifo.sv
module tokdec_ack_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign head    = slot_q[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tokdec_parser.sv
module tokdec_parser
  import tokdec_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tok_take,
  input  logic [TOK_W-1:0]      tok_data,
  output logic                  cfg_we,
  output logic [CH_W+IDX_W-1:0] cfg_waddr,
  output logic [TOK_W-1:0]      cfg_wdata,
  output logic                  issue,
  output logic [CH_W-1:0]       iss_ch,
  output logic [TOK_W-1:0]      iss_dst,
  output logic [TOK_W-1:0]      iss_src,
  output logic                  iss_a2b,
  output logic                  iss_clear,
  output logic                  iss_fast,
  output logic                  iss_need,
  output logic                  iss_to,
  output logic                  iss_from
);
  tok_state_e       state_q;
  logic [5:0]       cmd_q;
  logic [CH_W-1:0]  ch_q;
  logic [IDX_W-1:0] idx_q, cnt_q, widx;
  logic [TOK_W-1:0] dst_q, src_q;
  logic             to_q;

  logic [5:0]       h_cmd;
  logic [CH_W-1:0]  h_ch;
  logic [IDX_W-1:0] h_idx;
  logic             last_op;

  assign h_cmd = tok_data[5:0];
  assign h_ch  = tok_data[6 +: CH_W];
  assign h_idx = tok_data[6 + CH_W +: IDX_W];

  assign widx      = (state_q == ST_CFG) ? seq_to_idx(cnt_q) : idx_q;
  assign cfg_waddr = {ch_q, widx};
  assign cfg_wdata = tok_data & field_mask(widx);
  assign cfg_we    = tok_take && (state_q == ST_CFG || state_q == ST_PARAM);

  assign last_op = (cnt_q == 3'd3) || (cnt_q == 3'd2 && (cmd_q & CB_CLEAR) != 0);
  assign issue   = tok_take && (state_q == ST_XFER) && last_op;

  assign iss_ch    = ch_q;
  assign iss_dst   = dst_q;
  assign iss_src   = src_q;
  assign iss_a2b   = (cmd_q & CB_DIR) != 0;
  assign iss_clear = (cmd_q & CB_CLEAR) != 0;
  assign iss_fast  = (cmd_q & CB_FAST) != 0;
  assign iss_need  = (cmd_q & (CB_ACK | CB_CHECK)) == 0;
  assign iss_to    = (cnt_q == 3'd2) ? tok_data[0] : to_q;
  assign iss_from  = (cnt_q == 3'd3) ? tok_data[0] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HDR;
      cmd_q   <= '0;
      ch_q    <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      dst_q   <= '0;
      src_q   <= '0;
      to_q    <= 1'b0;
    end else if (tok_take) begin
      unique case (state_q)
        ST_HDR: begin
          cmd_q <= h_cmd;
          ch_q  <= h_ch;
          idx_q <= h_idx;
          cnt_q <= '0;
          if (h_cmd == CMD_CRUN)          state_q <= ST_HDR;
          else if ((h_cmd & CB_CFG) == 0) state_q <= ST_XFER;
          else if (h_cmd == CMD_LOAD)     state_q <= ST_CFG;
          else if ((h_cmd & CB_FAST) != 0) state_q <= ST_PARAM;
          else                            state_q <= ST_HDR;
        end
        ST_CFG: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 3'd7) state_q <= ST_HDR;
        end
        ST_PARAM: state_q <= ST_HDR;
        ST_XFER: begin
          cnt_q <= cnt_q + 1'b1;
          case (cnt_q)
            3'd0:    dst_q <= tok_data;
            3'd1:    src_q <= tok_data;
            3'd2:    to_q  <= tok_data[0];
            default: ;
          endcase
          if (last_op) state_q <= ST_HDR;
        end
        default: state_q <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/xfer_token_decoder.sv
module xfer_token_decoder
  import tokdec_pkg::*;
#(
  parameter int NUM_CH    = 32,
  parameter int ACK_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tok_valid,
  output logic                          tok_ready,
  input  logic [31:0]                   tok_data,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [$clog2(NUM_CH)-1:0]     req_ch,
  output logic [31:0]                   req_dst,
  output logic [31:0]                   req_src,
  output logic                          req_a2b,
  output logic                          req_clear,
  output logic                          req_fast,
  output logic                          req_need_ack,
  output logic                          req_to_var,
  output logic                          req_from_var,
  input  logic                          done,
  output logic                          ack_valid,
  output logic [31:0]                   ack_token,
  input  logic [$clog2(NUM_CH)-1:0]     cfg_rd_ch,
  input  logic [2:0]                    cfg_rd_idx,
  output logic [31:0]                   cfg_rd_data
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int AW   = CH_W + IDX_W;

  logic            tok_take, fifo_full, fifo_empty;
  logic            cfg_we, issue;
  logic [AW-1:0]   cfg_waddr;
  logic [TOK_W-1:0] cfg_wdata, iss_dst, iss_src;
  logic [CH_W-1:0] iss_ch;
  logic            iss_a2b, iss_clear, iss_fast, iss_need, iss_to, iss_from;
  logic [CH_W:0]   fifo_head;
  logic            ack_pop;

  assign tok_ready = !req_valid && !fifo_full;
  assign tok_take  = tok_valid && tok_ready;
  assign ack_pop   = done && !fifo_empty;

  tokdec_parser #(.CH_W(CH_W)) u_parse (
    .clk(clk), .rst(rst), .tok_take(tok_take), .tok_data(tok_data),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .issue(issue), .iss_ch(iss_ch), .iss_dst(iss_dst), .iss_src(iss_src),
    .iss_a2b(iss_a2b), .iss_clear(iss_clear), .iss_fast(iss_fast),
    .iss_need(iss_need), .iss_to(iss_to), .iss_from(iss_from)
  );

  tokdec_cfg_mem #(.AW(AW), .DW(TOK_W)) u_cfg (
    .clk(clk), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr({cfg_rd_ch, cfg_rd_idx}), .rdata(cfg_rd_data)
  );

  tokdec_ack_fifo #(.DEPTH(ACK_DEPTH), .W(CH_W + 1)) u_order (
    .clk(clk), .rst(rst), .push(issue), .push_data({iss_need, iss_ch}),
    .pop(ack_pop), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid    <= 1'b0;
      req_ch       <= '0;
      req_dst      <= '0;
      req_src      <= '0;
      req_a2b      <= 1'b0;
      req_clear    <= 1'b0;
      req_fast     <= 1'b0;
      req_need_ack <= 1'b0;
      req_to_var   <= 1'b0;
      req_from_var <= 1'b0;
    end else if (issue) begin
      req_valid    <= 1'b1;
      req_ch       <= iss_ch;
      req_dst      <= iss_dst;
      req_src      <= iss_src;
      req_a2b      <= iss_a2b;
      req_clear    <= iss_clear;
      req_fast     <= iss_fast;
      req_need_ack <= iss_need;
      req_to_var   <= iss_to;
      req_from_var <= iss_from;
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      ack_token <= '0;
    end else begin
      ack_valid <= ack_pop && fifo_head[CH_W];
      if (ack_pop) ack_token <= {{(32 - CH_W){1'b0}}, fifo_head[CH_W-1:0]};
    end
  end
endmodule

// File: rtl/tokdec_checker.sv
module tokdec_checker #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            tok_ready,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CH_W-1:0] req_ch,
  input logic            req_clear,
  input logic            req_from_var,
  input logic            done,
  input logic            ack_valid
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_ch));

  p_tok_block_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !tok_ready);

  p_single_issue_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_valid);

  p_ack_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(done));

  p_clear_no_from_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_clear |-> !req_from_var);
endmodule

bind xfer_token_decoder tokdec_checker #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .tok_ready(tok_ready), .req_valid(req_valid),
  .req_ready(req_ready), .req_ch(req_ch), .req_clear(req_clear),
  .req_from_var(req_from_var), .done(done), .ack_valid(ack_valid)
);

// File: tb/xfer_token_decoder_test.sv
`timescale 1ns/1ps
module xfer_token_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tok_valid = 1'b0;
  logic        tok_ready;
  logic [31:0] tok_data = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [4:0]  req_ch;
  logic [31:0] req_dst, req_src;
  logic        req_a2b, req_clear, req_fast, req_need_ack, req_to_var, req_from_var;
  logic        done = 1'b0;
  logic        ack_valid;
  logic [31:0] ack_token;
  logic [4:0]  cfg_rd_ch = '0;
  logic [2:0]  cfg_rd_idx = '0;
  logic [31:0] cfg_rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [74:0] exp_req[$];
  logic [31:0] exp_ack[$];
  logic [5:0]  pend[$];

  always #2 clk = ~clk;

  xfer_token_decoder uut (.*);

  task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [5:0] cmd, input logic [4:0] ch, input logic [2:0] idx);
    return {18'b0, idx, ch, cmd};
  endfunction

  task automatic send(input logic [31:0] t);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_data  = t;
    while (!tok_ready) @(negedge clk);
    @(posedge clk);
    #1 tok_valid = 1'b0;
  endtask

  task automatic xfer(input logic [5:0] cmd, input logic [4:0] ch, input logic [31:0] dst,
                      input logic [31:0] src, input logic tov, input logic fromv);
    logic need;
    need = (cmd & 6'h12) == 6'h00;
    exp_req.push_back({ch, dst, src, cmd[2], cmd[3], cmd[0], need, tov, cmd[3] ? 1'b0 : fromv});
    pend.push_back({need, ch});
    send(hdr(6'h3F, 5'd0, 3'd0));
    send(hdr(cmd, ch, 3'd0));
    send(dst);
    send(src);
    send({31'b0, tov});
    if (!cmd[3]) send({31'b0, fromv});
  endtask

  task automatic fire_done();
    logic [5:0] e;
    @(negedge clk);
    done = 1'b1;
    if (pend.size() > 0) begin
      e = pend.pop_front();
      if (e[5]) exp_ack.push_back({27'b0, e[4:0]});
    end
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic rdcheck(input logic [4:0] ch, input logic [2:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd_ch  = ch;
    cfg_rd_idx = idx;
    @(negedge clk);
    check(cfg_rd_data == exp, tag, {64'b0, cfg_rd_data}, {64'b0, exp});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid && req_ready) begin
        logic [74:0] got;
        got = {req_ch, req_dst, req_src, req_a2b, req_clear, req_fast, req_need_ack, req_to_var, req_from_var};
        if (exp_req.size() == 0) check(1'b0, "R5 unexpected request", {21'b0, got}, '0);
        else begin
          logic [74:0] e;
          e = exp_req.pop_front();
          check(got == e, "R6 request fields", {21'b0, got}, {21'b0, e});
        end
      end
      if (ack_valid) begin
        if (exp_ack.size() == 0) check(1'b0, "R8 unexpected ack", {64'b0, ack_token}, '0);
        else begin
          logic [31:0] e;
          e = exp_ack.pop_front();
          check(ack_token == e, "R8 ack token", {64'b0, ack_token}, {64'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(tok_ready == 1'b1, "R11 tok_ready", {95'b0, tok_ready}, 96'd1);
    check(req_valid == 1'b0, "R11 req_valid", {95'b0, req_valid}, 96'd0);
    check(ack_valid == 1'b0, "R11 ack_valid", {95'b0, ack_valid}, 96'd0);

    // R2/R3 full load of channel 5
    send(hdr(6'h20, 5'd5, 3'd0));
    send(32'hFFFF_FFF6);
    send(32'h1234_5678);
    send(32'hABCD_EF12);
    send(32'h0001_0200);
    send(32'h8765_4321);
    send(32'h0000_3344);
    send(32'hFFFF_FFFF);
    send(32'h0000_0123);
    rdcheck(5'd5, 3'd0, 32'h0000_0006, "R3 setup mask");
    rdcheck(5'd5, 3'd1, 32'h0000_0023, "R2 height index");
    rdcheck(5'd5, 3'd2, 32'h1234_5678, "R2 stride A");
    rdcheck(5'd5, 3'd3, 32'h0000_EF12, "R3 crop/elem A");
    rdcheck(5'd5, 3'd4, 32'h0000_0200, "R2 width A");
    rdcheck(5'd5, 3'd5, 32'h8765_4321, "R2 stride B");
    rdcheck(5'd5, 3'd6, 32'h0000_3344, "R2 crop/elem B");
    rdcheck(5'd5, 3'd7, 32'h0000_FFFF, "R3 width B");

    // R4 / R1 single parameter write
    send(hdr(6'h21, 5'd9, 3'd4));
    send(32'hDEAD_BEEF);
    rdcheck(5'd9, 3'd4, 32'h0000_BEEF, "R4 set width");
    rdcheck(5'd5, 3'd4, 32'h0000_0200, "R1 other channel untouched");
    send(hdr(6'h21, 5'd9, 3'd1));
    send(32'hFFFF_FF81);
    rdcheck(5'd9, 3'd1, 32'h0000_0081, "R4 set height");

    // R5/R6/R10 four transfers fill the queue
    xfer(6'h04, 5'd7, 32'h0000_0100, 32'h0000_0200, 1'b1, 1'b0);
    xfer(6'h08, 5'd2, 32'h0000_0040, 32'h0000_00A5, 1'b0, 1'b1);
    xfer(6'h13, 5'd31, 32'hCAFE_0000, 32'h0BAD_F00D, 1'b1, 1'b1);
    xfer(6'h0D, 5'd0, 32'h0000_0008, 32'h5555_AAAA, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    check(tok_ready == 1'b0, "R10 full blocks tokens", {95'b0, tok_ready}, 96'd0);
    fire_done();
    check(tok_ready == 1'b1, "R10 slot freed", {95'b0, tok_ready}, 96'd1);
    fire_done();
    fire_done();
    fire_done();
    fire_done();  // nothing outstanding: ignored
    @(negedge clk);
    check(ack_valid == 1'b0, "R10 stray done ignored", {95'b0, ack_valid}, 96'd0);

    // R7 backpressure on the request
    req_ready = 1'b0;
    xfer(6'h06, 5'd12, 32'h0000_1000, 32'h0000_2000, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req_valid == 1'b1, "R7 request held", {95'b0, req_valid}, 96'd1);
      check(tok_ready == 1'b0, "R7 tokens blocked", {95'b0, tok_ready}, 96'd0);
    end
    @(posedge clk);
    #1 req_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(req_valid == 1'b0, "R7 request released", {95'b0, req_valid}, 96'd0);
    fire_done();

    // R9 unknown codes dropped, next token is a header
    send(hdr(6'h22, 5'd3, 3'd0));
    send(hdr(6'h21, 5'd3, 3'd1));
    send(32'h0000_0077);
    rdcheck(5'd3, 3'd1, 32'h0000_0077, "R9 header after unknown");
    send(hdr(6'h2E, 5'd5, 3'd1));
    send(hdr(6'h3F, 5'd5, 3'd1));
    rdcheck(5'd5, 3'd1, 32'h0000_0023, "R9 unknown writes nothing");

    repeat (4) @(negedge clk);
    check(exp_req.size() == 0, "R5 all requests seen", exp_req.size(), 96'd0);
    check(exp_ack.size() == 0, "R8 all acks seen", exp_ack.size(), 96'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule